// File: doc/BRIEF.md
# LCD Frame Streamer from Linear Burst Memory

This block refreshes a 16-bit LCD panel that runs in data-enable framing. It keeps the panel's image in an external pseudo-static RAM with a double-data-rate interface. Two 8-bit devices sit side by side to form one 16-bit location. Once per frame period the block lowers chip select and sends a single start address. It waits out the fixed address latency, then reads the whole frame as one unbroken linear burst. Each location it receives becomes one panel pixel clock. Reading every location once per frame also keeps the RAM's contents refreshed.

Line and frame structure come from parameters: active pixels per line, blanking clocks per line, active lines, and blank lines. A location is shown as a pixel only while data-enable is high; every other location goes to the panel as black. When the burst ends, the block pulses `frame_done`, and a short host write port may then update single RAM locations until the next frame begins. A request that arrives while a frame is being read is held, with `wr_busy` high, until the burst is over. A write is only started if it can complete, and the minimum select-high gap can pass, before the next frame is due.

Top module: `lcd_frame_streamer`

## Requirements
- R1: During and right after reset, `mem_cs_n` is 1, and `lcd_de`, `lcd_pclk`, `wr_busy`, `mem_dq_oe`, `frame_start` and `frame_done` are all 0.
- R2: Each frame uses exactly one select-low transaction, lasting ADDR_CLKS + (ACT_PIX+BLANK_PIX)*(ACT_LINES+BLANK_LINES) cycles. The first word driven with `mem_dq_oe`=1 is {bit15 = 0 for read / 1 for write, address bits 30..16}. The second such word is address bits 15..0.
- R3: `frame_start` is high in the first select-low cycle of a frame. The data of location k (address frame_base+k, sampled at that start) appears on the LCD outputs ADDR_CLKS+1+k cycles after `frame_start`.
- R4: Location k lies at column k mod (ACT_PIX+BLANK_PIX) and line k div (ACT_PIX+BLANK_PIX). `lcd_de` is 1 only when the column is below ACT_PIX and the line is below ACT_LINES. When `lcd_de` is 0, the colour outputs are 0.
- R5: A 16-bit location w is output as RGB565: `lcd_r`=w[15:11], `lcd_g`=w[10:5], `lcd_b`=w[4:0]. Here `mem_dq_i[15:8]` comes from the upper device.
- R6: `lcd_pclk` pulses only in the cycles that present a streamed location. It is low at all other times.
- R7: Between transactions, `mem_cs_n` stays high for at least CS_GAP_CLKS cycles. No select-low run exceeds MAX_CS_CLKS cycles.
- R8: `frame_start` repeats every FRAME_PERIOD cycles. `frame_done` is high in the first select-high cycle after the read burst.
- R9: A request with `wr_req`=1 and `wr_busy`=0 is accepted, and `wr_busy` is 1 from the next cycle on. If the request arrives during a frame, the write waits until after `frame_done`. The write's select falls once select has been high CS_GAP_CLKS cycles. `wr_busy` returns to 0 after its ADDR_CLKS+1 select-low cycles.
- R10: A write transaction drives `wr_data` on `mem_dq_o` with `mem_dq_oe`=1 in its cycle ADDR_CLKS, and that location reads back with the new value. `lcd_de` stays 0 during any write.
- R11: A write is started only if its transaction plus the CS_GAP_CLKS gap ends before the next frame start. If not, it stays pending until after that frame.
- R12: `wr_req` is ignored while `wr_busy` is 1, and the RAM location it names is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_base | input | AW | Start address of the frame image, sampled at each frame start |
| wr_req | input | 1 | Host write request |
| wr_addr | input | AW | Host write address |
| wr_data | input | 16 | Host write data |
| wr_busy | output | 1 | Accepted write not yet completed |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_ck | output | 1 | RAM clock, toggling while selected |
| mem_dq_o | output | 16 | Address words and write data to the two RAM devices |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Read data from the two RAM devices |
| lcd_pclk | output | 1 | Panel pixel clock, rising mid-cycle |
| lcd_de | output | 1 | Panel data enable |
| lcd_r | output | 5 | Red field |
| lcd_g | output | 6 | Green field |
| lcd_b | output | 5 | Blue field |
| frame_start | output | 1 | Pulse in the first cycle of a frame read |
| frame_done | output | 1 | Pulse marking the opening of the write window |

## Verification
If the column or line counter drifts, the `lcd_de` pattern or the pixel values turn wrong at some location within the same frame. The bench compares every location of each frame, so such an error is caught within one frame period. A wrong latency counter shifts the whole image by one or more locations, and it shows at the very first pixel after `frame_start`. A write scheduler that loses or misplaces a pending request shows up as `wr_busy` staying high, as a select transaction appearing in a late slot, or as an altered pixel in the frame that follows.

// File: rtl/lcd_frame_streamer.sv
`timescale 1ns/1ps
module lcd_frame_streamer #(
  parameter int ACT_PIX      = 800,
  parameter int BLANK_PIX    = 88,
  parameter int ACT_LINES    = 480,
  parameter int BLANK_LINES  = 4,
  parameter int ADDR_CLKS    = 13,
  parameter int CS_GAP_CLKS  = 2,
  parameter int FRAME_PERIOD = 12_800_000,
  parameter int MAX_CS_CLKS  = 430_000,
  parameter int AW           = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] frame_base,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  output logic          wr_busy,
  output logic          mem_cs_n,
  output logic          mem_ck,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i,
  output logic          lcd_pclk,
  output logic          lcd_de,
  output logic [4:0]    lcd_r,
  output logic [5:0]    lcd_g,
  output logic [4:0]    lcd_b,
  output logic          frame_start,
  output logic          frame_done
);

  localparam int LINE_CLKS = ACT_PIX + BLANK_PIX;
  localparam int ALL_LINES = ACT_LINES + BLANK_LINES;
  localparam int WR_LEN    = ADDR_CLKS + 1;
  localparam int CUT       = FRAME_PERIOD - 1 - WR_LEN - CS_GAP_CLKS;
  localparam int XW = $clog2(LINE_CLKS + 1);
  localparam int YW = $clog2(ALL_LINES + 1);
  localparam int CW = $clog2(ADDR_CLKS + 1);
  localparam int FW = $clog2(FRAME_PERIOD + 1);
  localparam int GW = $clog2(CS_GAP_CLKS + 1);
  localparam int LW = $clog2(MAX_CS_CLKS + 2);

  localparam logic [XW-1:0] X_ACT  = XW'(ACT_PIX);
  localparam logic [XW-1:0] X_LAST = XW'(LINE_CLKS - 1);
  localparam logic [YW-1:0] Y_ACT  = YW'(ACT_LINES);
  localparam logic [YW-1:0] Y_LAST = YW'(ALL_LINES - 1);
  localparam logic [CW-1:0] C_ADDR = CW'(ADDR_CLKS);
  localparam logic [FW-1:0] F_LAST = FW'(FRAME_PERIOD - 1);
  localparam logic [FW-1:0] F_CUT  = FW'(CUT);
  localparam logic [GW-1:0] G_MIN  = GW'(CS_GAP_CLKS);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [CW-1:0] c;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [FW-1:0] fp;
  logic [GW-1:0] gap_cnt;
  logic [AW-1:0] base_q, wa_q;
  logic [15:0]   wd_q, pix_q;
  logic          run_q, de_q, fs_q, fd_q, ck_q;

  logic fp_last, gap_ok, streaming, de_now, rd_end, wr_end, start_rd, start_wr, nxt_idle;
  logic [30:0] ap;

  assign fp_last   = (fp == F_LAST);
  assign gap_ok    = (gap_cnt == G_MIN);
  assign streaming = (st == S_RD) && (c == C_ADDR);
  assign de_now    = streaming && (x < X_ACT) && (y < Y_ACT);
  assign rd_end    = streaming && (x == X_LAST) && (y == Y_LAST);
  assign wr_end    = (st == S_WR) && (c == C_ADDR);
  assign start_rd  = (st == S_IDLE) && fp_last;
  assign start_wr  = (st == S_IDLE) && !fp_last && wr_busy && gap_ok && (fp <= F_CUT);
  assign nxt_idle  = (st == S_IDLE) ? !(start_rd || start_wr) : (rd_end || wr_end);
  assign ap        = 31'(base_q);

  assign mem_cs_n  = (st == S_IDLE);
  assign mem_ck    = ck_q;
  assign mem_dq_oe = (st != S_IDLE) &&
                     ((c == CW'(0)) || (c == CW'(1)) || ((st == S_WR) && (c == C_ADDR)));
  assign mem_dq_o  = (c == CW'(0)) ? {(st == S_WR), ap[30:16]} :
                     (c == CW'(1)) ? ap[15:0] : wd_q;

  assign lcd_pclk    = run_q & ~clk;
  assign lcd_de      = de_q;
  assign lcd_r       = pix_q[15:11];
  assign lcd_g       = pix_q[10:5];
  assign lcd_b       = pix_q[4:0];
  assign frame_start = fs_q;
  assign frame_done  = fd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  c <= '0;  x <= '0;  y <= '0;  fp <= '0;
      gap_cnt <= G_MIN;  base_q <= '0;  wa_q <= '0;  wd_q <= '0;
      wr_busy <= 1'b0;  pix_q <= '0;  run_q <= 1'b0;  de_q <= 1'b0;
      fs_q <= 1'b0;  fd_q <= 1'b0;  ck_q <= 1'b0;
    end else begin
      fp    <= fp_last ? '0 : fp + FW'(1);
      fs_q  <= start_rd;
      fd_q  <= rd_end;
      run_q <= streaming;
      de_q  <= de_now;
      pix_q <= de_now ? mem_dq_i : '0;
      ck_q  <= nxt_idle ? 1'b0 : ~ck_q;

      if (!nxt_idle)            gap_cnt <= '0;
      else if (st != S_IDLE)    gap_cnt <= GW'(1);
      else if (!gap_ok)         gap_cnt <= gap_cnt + GW'(1);

      if (wr_req && !wr_busy) begin
        wr_busy <= 1'b1;
        wa_q    <= wr_addr;
        wd_q    <= wr_data;
      end else if (wr_end) begin
        wr_busy <= 1'b0;
      end

      case (st)
        S_IDLE: begin
          c <= '0;
          if (start_rd) begin
            st <= S_RD;  base_q <= frame_base;  x <= '0;  y <= '0;
          end else if (start_wr) begin
            st <= S_WR;  base_q <= wa_q;
          end
        end
        S_RD: begin
          if (c != C_ADDR)          c <= c + CW'(1);
          else if (rd_end)          st <= S_IDLE;
          else if (x == X_LAST) begin x <= '0; y <= y + YW'(1); end
          else                      x <= x + XW'(1);
        end
        S_WR: begin
          if (wr_end) st <= S_IDLE;
          else        c <= c + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [GW:0]   chk_hi;
  logic [LW-1:0] chk_lo;
  logic [FW:0]   chk_fp;
  logic          seen_fs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_hi <= (GW+1)'(CS_GAP_CLKS);  chk_lo <= '0;  chk_fp <= '0;  seen_fs <= 1'b0;
    end else begin
      chk_hi <= !mem_cs_n ? '0 : (chk_hi >= (GW+1)'(CS_GAP_CLKS)) ? chk_hi : chk_hi + 1'b1;
      chk_lo <= mem_cs_n ? '0 : (chk_lo == LW'(MAX_CS_CLKS + 1)) ? chk_lo : chk_lo + 1'b1;
      chk_fp <= frame_start ? '0 : (chk_fp > (FW+1)'(FRAME_PERIOD)) ? chk_fp : chk_fp + 1'b1;
      if (frame_start) seen_fs <= 1'b1;
    end
  end

  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (chk_hi >= (GW+1)'(CS_GAP_CLKS)));
  assert_cs_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lo <= LW'(MAX_CS_CLKS));
  assert_frame_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && seen_fs) |-> (chk_fp == (FW+1)'(FRAME_PERIOD - 1)));
  assert_start_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !mem_cs_n);
  assert_de_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_de) |-> $past(st == S_RD));
  assert_de_low_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |-> !lcd_de);
  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(wr_req));

endmodule

// File: tb/sim_lcd_frame_streamer.sv
`timescale 1ns/1ps
module sim_lcd_frame_streamer;
  localparam int ACT = 8, BLK = 3, AL = 4, BL = 2, ADR = 5, GAP = 3, FP = 200, MAXCS = 100, AW = 16;
  localparam int LINE = ACT + BLK;
  localparam int TOT  = LINE * (AL + BL);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] frame_base = '0, wr_addr = '0;
  logic wr_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_busy, mem_cs_n, mem_ck, mem_dq_oe, lcd_pclk, lcd_de, frame_start, frame_done;
  logic [15:0] mem_dq_o, mem_dq_i;
  logic [4:0] lcd_r, lcd_b;
  logic [5:0] lcd_g;

  always #2.5 clk = ~clk;

  lcd_frame_streamer #(.ACT_PIX(ACT), .BLANK_PIX(BLK), .ACT_LINES(AL), .BLANK_LINES(BL),
    .ADDR_CLKS(ADR), .CS_GAP_CLKS(GAP), .FRAME_PERIOD(FP), .MAX_CS_CLKS(MAXCS), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_base(frame_base), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_busy(wr_busy), .mem_cs_n(mem_cs_n), .mem_ck(mem_ck),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .lcd_pclk(lcd_pclk),
    .lcd_de(lcd_de), .lcd_r(lcd_r), .lcd_g(lcd_g), .lcd_b(lcd_b),
    .frame_start(frame_start), .frame_done(frame_done));

  function automatic logic [15:0] seed(input int i);
    return 16'((i * 40503 + 4660) & 32'hFFFF);
  endfunction

  // behavioural RAM pair
  logic [15:0] dev [256];
  logic [7:0]  scnt, rd_idx;
  logic        s_rw;
  logic [30:0] s_addr;
  logic [AW-1:0] last_rd;
  int oe_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dev[i] <= seed(i);
      scnt <= '0;  s_rw <= 1'b0;  s_addr <= '0;  last_rd <= '0;
    end else if (mem_cs_n) begin
      scnt <= '0;
    end else begin
      if (scnt != 8'hFF) scnt <= scnt + 8'd1;
      if (scnt == 8'd0) begin
        s_rw <= mem_dq_o[15];  s_addr[30:16] <= mem_dq_o[14:0];
        if (!mem_dq_oe) oe_err++;
      end
      if (scnt == 8'd1) begin
        s_addr[15:0] <= mem_dq_o;
        if (!mem_dq_oe) oe_err++;
        if (!s_rw) last_rd <= AW'({s_addr[30:16], mem_dq_o});
      end
      if (scnt == 8'(ADR) && s_rw) begin
        dev[s_addr[7:0]] <= mem_dq_o;
        if (!mem_dq_oe) oe_err++;
      end
    end
  end
  assign rd_idx   = s_addr[7:0] + (scnt - 8'(ADR));
  assign mem_dq_i = (!mem_cs_n && !s_rw && scnt >= 8'(ADR)) ? dev[rd_idx] : 16'hDEAD;

  // monitors
  int cyc = 0, hi = 0, lo = 0, min_gap = 100000, max_lo = 0, de_viol = 0;
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (mem_cs_n) begin
        if (lo > max_lo) max_lo = lo;
        lo = 0;  hi++;
      end else begin
        if (lo == 0 && hi < min_gap) min_gap = hi;
        hi = 0;  lo++;
      end
    end
  end
  always @(negedge clk)
    if (rst_n && !mem_cs_n && s_rw && scnt >= 8'd2 && lcd_de) de_viol++;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_mem [256];
  logic [15:0] cap [TOT];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic wait_fs;
    step;
    while (!frame_start) step;
  endtask

  task automatic host_write(input int a, input logic [15:0] d);
    wr_addr = AW'(a);  wr_data = d;  wr_req = 1'b1;
    step;
    wr_req = 1'b0;
  endtask

  // called in the frame_start cycle
  task automatic check_frame(input int base);
    int de_bad = 0, px_bad = 0, ck_bad = 0, cs_bad = 0;
    int px_a = 0, px_e = 0, de_a = 0, de_e0 = 0;
    bit fd = 0, cs_end = 0, ck_after, de_after;
    repeat (ADR) begin step; if (mem_cs_n) cs_bad++; end
    for (int k = 0; k < TOT; k++) begin
      logic de_e;
      logic [15:0] pe, got;
      step;
      de_e = ((k % LINE) < ACT) && ((k / LINE) < AL);
      pe   = de_e ? exp_mem[(base + k) & 255] : 16'h0;
      got  = {lcd_r, lcd_g, lcd_b};
      cap[k] = got;
      if (lcd_de !== de_e) begin if (de_bad == 0) begin de_a = k; de_e0 = int'(de_e); end de_bad++; end
      if (got !== pe) begin if (px_bad == 0) begin px_a = got; px_e = pe; end px_bad++; end
      if (lcd_pclk !== 1'b1) ck_bad++;
      if (k < TOT - 1 && mem_cs_n) cs_bad++;
      if (k == TOT - 1) begin fd = frame_done; cs_end = mem_cs_n; end
    end
    step;
    ck_after = lcd_pclk;  de_after = lcd_de;
    chk(de_bad == 0 && !de_after, "R4 data-enable line/frame pattern (first bad location)", de_a, de_e0);
    chk(px_bad == 0, "R3 R5 pixel value order and RGB565 fields", px_a, px_e);
    chk(ck_bad == 0 && !ck_after, "R6 pixel clock only while streaming", ck_bad, 0);
    chk(cs_bad == 0 && cs_end, "R2 select held low for whole burst", cs_bad, 0);
    chk(fd, "R8 frame_done at select release", int'(fd), 1);
    chk(last_rd == AW'(base), "R2 single start address word", int'(last_rd), base);
  endtask

  task automatic test_reset;
    repeat (4) step;
    chk(mem_cs_n && !lcd_de && !wr_busy && !mem_dq_oe, "R1 outputs held in reset", int'(mem_cs_n), 1);
    rst_n = 1'b1;
    step;
    chk(mem_cs_n && !lcd_de && !lcd_pclk && !wr_busy && !frame_start && !frame_done && !mem_dq_oe,
        "R1 idle state after reset", int'(lcd_de), 0);
  endtask

  task automatic test_frames;
    int t0;
    frame_base = '0;
    wait_fs;  check_frame(0);
    frame_base = AW'(40);
    wait_fs;  t0 = cyc;  check_frame(40);
    frame_base = '0;
    wait_fs;
    chk(cyc - t0 == FP, "R8 frame repeat period", cyc - t0, FP);
    check_frame(0);
  endtask

  task automatic test_write_in_frame;
    int first_lo = 0, done = 0;
    wait_fs;
    repeat (10) step;
    host_write(2, 16'hF81F);  exp_mem[2] = 16'hF81F;
    chk(wr_busy, "R9 busy after accepted request", int'(wr_busy), 1);
    host_write(5, 16'h07E0);
    while (!frame_done) step;
    chk(wr_busy, "R9 request held through frame burst", int'(wr_busy), 1);
    for (int i = 1; i <= 20; i++) begin
      step;
      if (!mem_cs_n && first_lo == 0) first_lo = i;
      if (!wr_busy) begin done = i; break; end
    end
    chk(first_lo == GAP, "R9 write select after gap", first_lo, GAP);
    chk(done == GAP + ADR + 1, "R9 busy clears after write transaction", done, GAP + ADR + 1);
    wait_fs;  check_frame(0);
    chk(cap[2] == 16'hF81F, "R10 written location reads back", cap[2], 16'hF81F);
    chk(cap[5] == seed(5), "R12 request while busy left location unchanged", cap[5], seed(5));
  endtask

  task automatic test_write_window;
    int done = 0;
    host_write(13, 16'h001F);  exp_mem[13] = 16'h001F;
    for (int i = 1; i <= 20; i++) begin
      step;
      if (!wr_busy) begin done = i; break; end
    end
    chk(done >= ADR + 1 && done <= ADR + GAP + 2, "R9 write in open window completes", done, ADR + GAP);
    wait_fs;  check_frame(0);
    chk(cap[13] == 16'h001F, "R10 window write visible", cap[13], 16'h001F);
  endtask

  task automatic test_cutoff;
    int lo_cnt = 0;
    wait_fs;
    repeat (195) step;
    host_write(12, 16'hABCD);
    while (!frame_start) begin
      if (!mem_cs_n) lo_cnt++;
      step;
    end
    chk(lo_cnt == 0, "R11 no write started too close to frame", lo_cnt, 0);
    chk(wr_busy, "R11 late request still pending at frame start", int'(wr_busy), 1);
    check_frame(0);
    chk(cap[12] == seed(12), "R11 deferred write not yet applied", cap[12], seed(12));
    while (wr_busy) step;
    exp_mem[12] = 16'hABCD;
    wait_fs;  check_frame(0);
    chk(cap[12] == 16'hABCD, "R11 deferred write applied after frame", cap[12], 16'hABCD);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
    test_reset;
    test_frames;
    test_write_in_frame;
    test_write_window;
    test_cutoff;
    chk(min_gap >= GAP, "R7 minimum select-high gap", min_gap, GAP);
    chk(max_lo == ADR + TOT && max_lo <= MAXCS, "R7 longest select-low run", max_lo, ADR + TOT);
    chk(de_viol == 0, "R10 data enable low during writes", de_viol, 0);
    chk(oe_err == 0, "R2 address and data words driven", oe_err, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;  n_bad++;
    $display("FAIL watchdog: run did not finish, got %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule